// File: doc/BRIEF.md
# Blocking Single-Word Mailbox Between Neighbor Cores

This block is a one-word register that links two adjacent processor cores. One core only writes into it and the other only reads from it. Neither core ever looks at a status flag. Flow control is done entirely by stalling: a write into an occupied register or a read from an empty one raises that side's stall output, and the requesting core holds its instruction until the stall drops. The held instruction then completes as issued.

Each register has a single producer and a single consumer, so there is no arbitration and no priority logic. An internal occupancy flag is the only state besides the stored word. That flag changes only when a write or a read completes. The stall outputs are combinational in the request and the flag. The read data comes straight from the storage register, so there is no combinational path from write data to read data.

Top module: `blocking_mailbox`

## Requirements
- R1: A synchronous active-high `rst` empties the register. In the first cycle after reset, a read request stalls (`rd_stall`=1) and a write request does not stall (`wr_stall`=0).
- R2: A write into an empty register completes in the cycle it is requested (`wr_stall`=0). It stores `wr_data` and marks the register full on that rising edge. A read in a later cycle returns that word with `rd_stall`=0.
- R3: A write request while the register is full raises `wr_stall` and leaves the stored word unchanged.
- R4: A stalled write completes, with its held data, in the cycle after the reader completes a read of the stored word. A later read returns the held data.
- R5: A read request while the register is empty raises `rd_stall`.
- R6: A stalled read completes in the cycle after a write completes, and it returns the newly written word.
- R7: When the register is full and a read and a write are both requested, the read completes with the old word and the write stalls.
- R8: When the register is empty and a read and a write are both requested, the write completes and the read stalls. On the next cycle the read returns the new word.
- R9: With no request on a side, that side's stall output is 0.
- R10: The occupancy changes only through a completed write (empty to full) or a completed read (full to empty). Idle cycles keep the stored word readable.
- R11: Input contract: a side that sees its stall keeps its request high in the next cycle, and a writer also keeps `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Writer requests to deposit a word |
| wr_data | input | DATA_W | Word offered by the writer |
| wr_stall | output | 1 | Writer must hold its request this cycle |
| rd_req | input | 1 | Reader requests to take the word |
| rd_data | output | DATA_W | Stored word, valid when a read completes |
| rd_stall | output | 1 | Reader must hold its request this cycle |

## Verification
The assertions assume that both cores honour the hold contract of R11. A stalled request stays high into the next cycle, and a stalled writer keeps its data stable; the checks on completion and on stored-word stability rely on this. The bench's long sweep draws requests and data from a pseudo-random sequence, but any side that was stalled in the previous cycle repeats its request unchanged. The directed sequences are built to keep the same rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {
    OCC_EMPTY = 1'b0,
    OCC_FULL  = 1'b1
  } occ_e;

endpackage

// File: rtl/mbx_occupancy.sv
module mbx_occupancy
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_fire,
  output logic rd_fire,
  output logic wr_stall,
  output logic rd_stall,
  output occ_e occ
);

  occ_e occ_q;
  logic is_full;

  assign is_full  = (occ_q == OCC_FULL);
  assign wr_stall = wr_req &  is_full;
  assign rd_stall = rd_req & ~is_full;
  assign wr_fire  = wr_req & ~is_full;
  assign rd_fire  = rd_req &  is_full;
  assign occ      = occ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= OCC_EMPTY;
    end else if (wr_fire) begin
      occ_q <= OCC_FULL;
    end else if (rd_fire) begin
      occ_q <= OCC_EMPTY;
    end
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
    rst |=> occ_q == OCC_EMPTY); // R1

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!wr_req |-> !wr_stall) and (!rd_req |-> !rd_stall)); // R9

  AST_OCC_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
    (!wr_fire && !rd_fire) |=> $stable(occ_q)); // R10

endmodule

// File: rtl/mbx_word_store.sv
module mbx_word_store #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (load) begin
      word_q <= din;
    end
  end

  assign dout = word_q;

endmodule

// File: rtl/blocking_mailbox.sv
module blocking_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_stall,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_stall
);

  logic wr_fire;
  logic rd_fire;
  occ_e occ;

  mbx_occupancy occ_i (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .wr_stall (wr_stall),
    .rd_stall (rd_stall),
    .occ      (occ)
  );

  mbx_word_store #(.DATA_W(DATA_W)) store_i (
    .clk  (clk),
    .load (wr_fire),
    .din  (wr_data),
    .dout (rd_data)
  );

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_FULL && wr_req) |-> wr_stall); // R3

  AST_STORE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(rd_data)); // R3

  AST_EMPTY_READ_STALL: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_EMPTY && rd_req) |-> rd_stall); // R5

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_stall) |=> (occ == OCC_FULL && rd_data == $past(wr_data))); // R2

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_stall) |=> occ == OCC_EMPTY); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_stall |=> (wr_req && $stable(wr_data))); // R11

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_stall |=> rd_req); // R11

endmodule

// File: tb/blocking_mailbox_tb_top.sv
module blocking_mailbox_tb_top;

  localparam int DATA_W = 18;
  localparam int WATCHDOG_CYCLES = 200000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_req = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_req = 1'b0;
  logic              wr_stall;
  logic              rd_stall;
  logic [DATA_W-1:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  logic              m_full = 1'b0;
  logic [DATA_W-1:0] m_word = '0;

  always #10 clk = ~clk;

  blocking_mailbox #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_req(rd_req), .rd_data(rd_data), .rd_stall(rd_stall)
  );

  task automatic check(input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check just after, then let the rising edge act.
  task automatic step(input string tag, input logic w, input logic [DATA_W-1:0] d,
                      input logic r);
    @(negedge clk);
    wr_req  = w;
    wr_data = d;
    rd_req  = r;
    #2;
    check(tag, "wr_stall", {{(DATA_W-1){1'b0}}, wr_stall}, {{(DATA_W-1){1'b0}}, w & m_full});
    check(tag, "rd_stall", {{(DATA_W-1){1'b0}}, rd_stall}, {{(DATA_W-1){1'b0}}, r & ~m_full});
    if (r && m_full) check(tag, "rd_data", rd_data, m_word);
    if (w && !m_full) begin
      m_full = 1'b1;
      m_word = d;
    end else if (r && m_full) begin
      m_full = 1'b0;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic        w_prev_stall;
    logic        r_prev_stall;
    logic        w;
    logic        r;
    logic [DATA_W-1:0] d;
    string tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset; read stalls, write goes through (R8 pairing)
    step("R1", 1'b1, 18'h2A5A5, 1'b1);
    // R8 second half / R6: held read completes with the new word
    step("R8", 1'b0, '0, 1'b1);

    // R9: no requests, no stalls
    step("R9", 1'b0, '0, 1'b0);

    // R2: write into empty, then read it back after idle cycles (R10)
    step("R2", 1'b1, 18'h1BEEF, 1'b0);
    step("R10", 1'b0, '0, 1'b0);
    step("R10", 1'b0, '0, 1'b0);
    step("R2", 1'b0, '0, 1'b1);

    // R3 / R7 / R4: blocked writer waits for the reader
    step("R2", 1'b1, 18'h00111, 1'b0);
    step("R3", 1'b1, 18'h3C0DE, 1'b0);
    step("R7", 1'b1, 18'h3C0DE, 1'b1);
    step("R4", 1'b1, 18'h3C0DE, 1'b0);
    step("R4", 1'b0, '0, 1'b1);

    // R5 / R6: blocked reader waits for the writer
    step("R5", 1'b0, '0, 1'b1);
    step("R5", 1'b0, '0, 1'b1);
    step("R8", 1'b1, 18'h0F00D, 1'b1);
    step("R6", 1'b0, '0, 1'b1);

    // Near-exhaustive sweep honouring the hold contract (R11)
    lfsr = 16'hACE1;
    w_prev_stall = 1'b0;
    r_prev_stall = 1'b0;
    d = '0;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (w_prev_stall) begin
        w = 1'b1;
      end else begin
        w = lfsr[0];
        d = {lfsr[1:0], lfsr} ^ DATA_W'(i);
      end
      r = r_prev_stall ? 1'b1 : lfsr[5];
      if (w && r) tag = m_full ? "R7" : "R8";
      else if (w)  tag = m_full ? "R3" : "R2";
      else if (r)  tag = m_full ? "R4" : "R5";
      else         tag = "R9";
      w_prev_stall = w & m_full;
      r_prev_stall = r & ~m_full;
      step(tag, w, d, r);
    end

    @(negedge clk);
    wr_req = 1'b0;
    rd_req = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule